// File: doc/BRIEF.md
# In-Flight Command Tracking Queue

This block keeps a record of requests sent to a memory controller whose answers come back in issue order but after a delay that cannot be predicted. Each time a request is issued, the issuer strobes `wr_en` with a copy of the request on `cmd_in`. Each time the controller reports a completion, the consumer strobes `rd_en` to retire the oldest record. The consumer can then tell which kind of request has just finished, for example whether returning data is expected.

Records are held in a small register array. The entry at the read pointer drives `cmd_out` combinationally. The oldest outstanding record is therefore visible as soon as it exists, with no read request and no registered output stage. `empty` low qualifies `cmd_out`.

Both pointers are log2(DEPTH) bits wide and wrap by natural overflow. Full and empty are told apart by leaving one slot unused, so at most DEPTH-1 records are held at a time. A strobe that the current state blocks is dropped. The reset is synchronous and active low.

Top module: `cmdq_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the queue is cleared: after that edge `empty` is 1 and `full` is 0.
- R2: A write accepted on an empty queue places `cmd_in` at the head. After that same edge, `cmd_out` equals the written value and `empty` is 0.
- R3: Records leave in exactly the order in which they were accepted.
- R4: `empty` is 1 exactly when no accepted record remains unretired.
- R5: `full` is 1 exactly when DEPTH-1 records are held. This is the usable capacity.
- R6: A write strobed while `full` is 1 is dropped. No record is added, and the records already held come out unchanged.
- R7: A read strobed while `empty` is 1 is dropped. The next written record is the one that then appears at `cmd_out`.
- R8: A read and a write in the same cycle, neither blocked, are both accepted. The occupancy stays the same and order is kept.
- R9: Both pointers wrap from DEPTH-1 to 0. Ordering stays correct over runs longer than DEPTH records.
- R10: After an accepted read on a full queue, `full` is 0 following that edge.
- R11: After an accepted read that leaves the queue non-empty, `cmd_out` shows the next record directly after that edge, with no added cycle. While no read is accepted, `cmd_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Record strobe for `cmd_in` |
| cmd_in | input | WIDTH | Request copy to be recorded |
| full | output | 1 | No free slot; writes are dropped |
| cmd_out | output | WIDTH | Oldest held record, combinational |
| rd_en | input | 1 | Retire-oldest strobe |
| empty | output | 1 | No record held; `cmd_out` not valid |

## Verification
Every result of this block is due at the first rising edge after the strobe that causes it: there is one register stage (the pointers and the array), and the flags and `cmd_out` follow from it combinationally. The bench drives strobes on the falling edge. It compares `empty`, `full` and `cmd_out` against its queue model a quarter period later, which is before the next rising edge and after the previous one has settled. The model is updated only at the rising edge, using the flag values just compared. A check in cycle N therefore always describes the strobes from cycle N-1.

// File: rtl/cmdq_pkg.sv
// Package: shared helpers for the command tracking queue.
// Assumes: DEPTH values handed to these helpers are positive.
package cmdq_pkg;

    // True when n is a non-zero power of two.
    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

    // Pointer width for a given depth (at least one bit).
    function automatic int ptr_bits(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cmdq_ptr.sv
// Module: cmdq_ptr
// A wrapping position counter. It advances by one on an accepted strobe and
// wraps by natural overflow of its AW bits.
// Assumes: the depth served is exactly 2**AW entries.
module cmdq_ptr #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_nxt
);

    // Next position: plain increment, rolls over from all-ones to zero.
    always_comb begin
        ptr_nxt = ptr + AW'(1);
    end

    // Position register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr_nxt;
        end
    end

endmodule

// File: rtl/cmdq_store.sv
// Module: cmdq_store
// A register array with one write port and one combinational read port.
// Assumes: the write address and the read address are in range; data
// content is not cleared by reset because flags qualify it.
module cmdq_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] slot [DEPTH];

    // One register per slot, loaded when its address is written.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(g))) begin
                slot[g] <= wdata;
            end
        end
    end

    // Fall-through read of the addressed slot.
    always_comb begin
        rdata = slot[raddr];
    end

endmodule

// File: rtl/cmdq_status.sv
// Module: cmdq_status
// Derives the occupancy flags from the two pointers and decides which
// strobes are accepted.
// Assumes: one slot is always left unused, so equal pointers mean empty.
module cmdq_status #(
    parameter int AW = 3
) (
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] wr_ptr_nxt,
    input  logic [AW-1:0] rd_ptr,
    output logic          empty,
    output logic          full,
    output logic          wr_acc,
    output logic          rd_acc
);

    // Flags: empty when the pointers meet, full when the writer is one behind.
    always_comb begin
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr_nxt == rd_ptr);
    end

    // Acceptance: a strobe is dropped when its side is blocked.
    always_comb begin
        wr_acc = wr_en && !full;
        rd_acc = rd_en && !empty;
    end

endmodule

// File: rtl/cmdq_tracker.sv
// Module: cmdq_tracker (top)
// A queue of in-flight commands with a fall-through head. It holds up to
// DEPTH-1 records and releases them in issue order.
// Assumes: DEPTH is a power of two of at least 2; a single clock domain.
module cmdq_tracker #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] cmd_in,
    output logic             full,
    output logic [WIDTH-1:0] cmd_out,
    input  logic             rd_en,
    output logic             empty
);

    localparam int AW = cmdq_pkg::ptr_bits(DEPTH);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] wr_ptr_nxt;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] rd_ptr_nxt;
    logic          wr_acc;
    logic          rd_acc;

    cmdq_status #(.AW(AW)) u_status (
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wr_ptr     (wr_ptr),
        .wr_ptr_nxt (wr_ptr_nxt),
        .rd_ptr     (rd_ptr),
        .empty      (empty),
        .full       (full),
        .wr_acc     (wr_acc),
        .rd_acc     (rd_acc)
    );

    cmdq_ptr #(.AW(AW)) u_wr_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (wr_acc),
        .ptr     (wr_ptr),
        .ptr_nxt (wr_ptr_nxt)
    );

    cmdq_ptr #(.AW(AW)) u_rd_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (rd_acc),
        .ptr     (rd_ptr),
        .ptr_nxt (rd_ptr_nxt)
    );

    cmdq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (wr_ptr),
        .wdata (cmd_in),
        .raddr (rd_ptr),
        .rdata (cmd_out)
    );

endmodule

// File: rtl/cmdq_tracker_chk.sv
// Module: cmdq_tracker_chk
// Property checker for cmdq_tracker. It keeps its own occupancy count from
// the port strobes and relates it to the flags and pointers.
// Assumes: bound into every cmdq_tracker instance.
module cmdq_tracker_chk #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             full,
    input logic             empty,
    input logic [WIDTH-1:0] cmd_out,
    input logic [AW-1:0]    wr_ptr,
    input logic [AW-1:0]    rd_ptr
);

    logic [AW:0] held;

    // Parameter sanity: depth must be a power of two.
    initial begin
        a_r9_depth_pow2: assert (cmdq_pkg::is_pow2(DEPTH));
    end

    // Occupancy shadow built from accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            case ({wr_en && !full, rd_en && !empty})
                2'b10:   held <= held + 1'b1;
                2'b01:   held <= held - 1'b1;
                default: held <= held;
            endcase
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (empty && !full));

    a_r4_empty_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (held == '0));

    a_r5_full_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        full == (held == (AW+1)'(DEPTH - 1)));

    a_r6_write_dropped_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && $stable(wr_ptr)));

    a_r7_read_dropped_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_ptr)));

    a_r9_read_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr == AW'(DEPTH - 1) && rd_en && !empty) |=> (rd_ptr == '0));

    a_r10_full_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_en) |=> !full);

    a_r11_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !rd_en) |=> $stable(cmd_out));

endmodule

bind cmdq_tracker cmdq_tracker_chk #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .AW    (AW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .full    (full),
    .empty   (empty),
    .cmd_out (cmd_out),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr)
);

// File: tb/tb_cmdq_tracker.sv
module tb_cmdq_tracker;

    localparam int CLK_P = 10;
    localparam int DEPTH = 8;
    localparam int WIDTH = 16;
    localparam int CAP   = DEPTH - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] cmd_in = '0;
    logic             full;
    logic             empty;
    logic [WIDTH-1:0] cmd_out;

    int checks = 0;
    int errors = 0;
    int seq    = 0;
    logic [WIDTH-1:0] model [$];

    always #(CLK_P/2) clk = ~clk;

    cmdq_tracker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .cmd_in  (cmd_in),
        .full    (full),
        .cmd_out (cmd_out),
        .rd_en   (rd_en),
        .empty   (empty)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare the outputs with the scoreboard state.
    task automatic compare(input string tag);
        logic exp_empty;
        logic exp_full;
        exp_empty = (model.size() == 0);
        exp_full  = (model.size() == CAP);
        check(empty === exp_empty, tag, "empty", WIDTH'(empty), WIDTH'(exp_empty));
        check(full === exp_full, tag, "full", WIDTH'(full), WIDTH'(exp_full));
        if (!exp_empty) begin
            check(cmd_out === model[0], tag, "cmd_out", cmd_out, model[0]);
        end
    endtask

    // Driver: one cycle of strobes; the scoreboard is updated at the edge.
    task automatic step(input bit w, input bit r, input string tag);
        logic [WIDTH-1:0] d;
        bit acc_w;
        bit acc_r;
        @(negedge clk);
        d = WIDTH'(16'hA000 + seq);
        wr_en  = w;
        rd_en  = r;
        cmd_in = d;
        #(CLK_P/4);
        compare(tag);
        acc_w = w && (model.size() != CAP);
        acc_r = r && (model.size() != 0);
        @(posedge clk);
        if (acc_r) void'(model.pop_front());
        if (acc_w) begin
            model.push_back(d);
            seq++;
        end
    endtask

    task automatic settle(input string tag);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        #(CLK_P/4);
        compare(tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        #(CLK_P/4);
        check(empty === 1'b1, "R1", "empty after reset", WIDTH'(empty), 1);
        check(full === 1'b0, "R1", "full after reset", WIDTH'(full), 0);
        rst_n = 1'b1;

        // R2: a single write falls through to the head.
        step(1, 0, "R2");
        settle("R2");

        // R3, R11: several writes, then reads one by one.
        for (int i = 0; i < 3; i++) step(1, 0, "R3");
        for (int i = 0; i < 4; i++) step(0, 1, "R11");
        settle("R4");

        // R5, R6: fill to capacity, then push while full.
        for (int i = 0; i < CAP; i++) step(1, 0, "R5");
        for (int i = 0; i < 3; i++) step(1, 0, "R6");
        settle("R5");

        // R10: one read releases full.
        step(0, 1, "R10");
        settle("R10");

        // R6: the data held while full drains unchanged.
        for (int i = 0; i < CAP; i++) step(0, 1, "R6");
        settle("R4");

        // R7: reads while empty are dropped.
        for (int i = 0; i < 3; i++) step(0, 1, "R7");
        step(1, 0, "R7");
        settle("R7");

        // R8: simultaneous read and write at steady occupancy.
        step(1, 0, "R8");
        for (int i = 0; i < 5; i++) step(1, 1, "R8");
        settle("R8");
        step(1, 1, "R8");

        // R9: long mixed run wrapping both pointers several times.
        for (int i = 0; i < 6 * DEPTH; i++) begin
            step((i % 3) != 2, (i % 4) != 0, "R9");
        end
        for (int i = 0; i < DEPTH; i++) step(0, 1, "R9");
        settle("R4");

        // R8 with full: the write is blocked, the read is taken.
        for (int i = 0; i < CAP; i++) step(1, 0, "R5");
        step(1, 1, "R8");
        settle("R10");
        for (int i = 0; i < CAP; i++) step(0, 1, "R3");
        settle("R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule